// File: doc/BRIEF.md
# Random Trigger and Hit Pulse Generator

This block makes two streams of pseudo-random single-cycle pulses for exercising readout logic without a real detector. Each stream has a 32-bit threshold input. The block compares that threshold with a fresh random word on every clock. A hit pulse can occur on any clock, and its probability per clock is H/2^32. A trigger pulse can occur only in a bunch-crossing slot, and its probability per crossing is T/2^32.

The block divides the clock by eight to make the crossing strobe and drives that strobe out next to the pulses. The trigger and hit decisions each draw from their own linear-feedback shift register. The two registers start from different seeds, so the two pulse streams do not track each other. A controller sets the rates by writing the trigger threshold (control word 0) and the hit threshold (control word 1) onto the two threshold inputs.

Top module: `rand_trig_hit_gen`

## Requirements
- R1: While rst_ni is low, bx_o, trig_o and hit_o are 0. Reset puts the crossing divider at phase 0 and loads each random register with its seed: 32'h0000_0001 for triggers and 32'hACE1_2468 for hits.
- R2: bx_o is high for exactly one cycle in every 8. Its first pulse is the cycle after the first rising clock edge after reset is released.
- R3: On every clock, each random word advances as a right-shifting Galois LFSR: s' = (s >> 1) ^ (s[0] ? 32'h8020_0003 : 0). A word is never zero.
- R4: At each clock edge, trig_o is loaded with 1 exactly when the divider is at phase 0 and the current trigger word is strictly less than trig_thresh_i. trig_o is therefore never high while bx_o is low.
- R5: A trigger threshold of 0 never produces a trigger. A trigger threshold of 32'hFFFF_FFFF produces a trigger at every crossing.
- R6: At each clock edge, hit_o is loaded with 1 exactly when the current hit word is strictly less than hit_thresh_i. A hit threshold of 0 never produces a hit, and 32'hFFFF_FFFF produces a hit on every clock.
- R7: Over 2^16 clocks, a trigger threshold of 2^31 gives 4096 ± 400 triggers and a hit threshold of 2^30 gives 16384 ± 1024 hits.
- R8: A threshold change takes effect at the next clock edge, with no extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_thresh_i | input | 32 | Trigger probability per crossing, T/2^32 |
| hit_thresh_i | input | 32 | Hit probability per clock, H/2^32 |
| bx_o | output | 1 | Bunch-crossing strobe, one cycle in eight |
| trig_o | output | 1 | Trigger pulse, one cycle |
| hit_o | output | 1 | Hit pulse, one cycle |

## Verification
The assertions assume that both thresholds are stable and defined at every rising edge. They also assume that a zero threshold, once applied, holds across the following edge before the zero-rate properties are judged. The bench meets these assumptions by changing the thresholds only at falling edges. It holds thresholds of zero for long stretches, holds all-ones for a shorter run, and then changes to random thresholds every sixteen clocks. A scoreboard model built from the LFSR recurrence and the phase-0 rule predicts every output cycle. A final 2^16-cycle window measures the two rates against the programmed probabilities.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int unsigned RW       = 32;
  localparam logic [RW-1:0] POLY   = 32'h8020_0003;
  localparam logic [RW-1:0] SEED_T = 32'h0000_0001;
  localparam logic [RW-1:0] SEED_H = 32'hACE1_2468;
  localparam int unsigned BX_DIV   = 8;
endpackage

// File: rtl/rtg_lfsr.sv
module rtg_lfsr #(
  parameter int unsigned W        = 32,
  parameter logic [W-1:0] POLY    = '1,
  parameter logic [W-1:0] SEED    = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] word_o
);
  logic [W-1:0] state_q, state_d;

  always_comb begin
    state_d = {1'b0, state_q[W-1:1]};
    if (state_q[0]) state_d = state_d ^ POLY;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= state_d;
  end

  assign word_o = state_q;
endmodule

// File: rtl/rtg_bx_div.sv
module rtg_bx_div #(
  parameter int unsigned DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic phase0_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign phase0_o = (cnt_q == '0);
endmodule

// File: rtl/rtg_fire.sv
module rtg_fire #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] word_i,
  input  logic [W-1:0] thresh_i,
  output logic         fire_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fire_o <= 1'b0;
    else         fire_o <= en_i && (word_i < thresh_i);
  end
endmodule

// File: rtl/rand_trig_hit_gen.sv
module rand_trig_hit_gen
  import rtg_pkg::*;
#(
  parameter int unsigned    W      = RW,
  parameter logic [W-1:0]   POLY_P = POLY,
  parameter logic [W-1:0]   SEED_TRIG = SEED_T,
  parameter logic [W-1:0]   SEED_HIT  = SEED_H,
  parameter int unsigned    DIV    = BX_DIV
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] trig_thresh_i,
  input  logic [W-1:0] hit_thresh_i,
  output logic         bx_o,
  output logic         trig_o,
  output logic         hit_o
);
  logic [W-1:0] trig_word, hit_word;
  logic         phase0;

  rtg_lfsr #(.W(W), .POLY(POLY_P), .SEED(SEED_TRIG)) u_lfsr_trig (
    .clk_i(clk_i), .rst_ni(rst_ni), .word_o(trig_word));

  rtg_lfsr #(.W(W), .POLY(POLY_P), .SEED(SEED_HIT)) u_lfsr_hit (
    .clk_i(clk_i), .rst_ni(rst_ni), .word_o(hit_word));

  rtg_bx_div #(.DIV(DIV)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .phase0_o(phase0));

  rtg_fire #(.W(W)) u_fire_trig (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(phase0),
    .word_i(trig_word), .thresh_i(trig_thresh_i), .fire_o(trig_o));

  rtg_fire #(.W(W)) u_fire_hit (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(1'b1),
    .word_i(hit_word), .thresh_i(hit_thresh_i), .fire_o(hit_o));

  // strobe registered so it lines up with the trigger decision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bx_o <= 1'b0;
    else         bx_o <= phase0;
  end
endmodule

// File: rtl/rtg_chk.sv
module rtg_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] trig_thresh_i,
  input logic [W-1:0] hit_thresh_i,
  input logic         bx_o,
  input logic         trig_o,
  input logic         hit_o,
  input logic [W-1:0] trig_word,
  input logic [W-1:0] hit_word
);
  logic [2:0] gap_q;
  logic       seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      gap_q  <= bx_o ? 3'd0 : gap_q + 3'd1;
      if (bx_o) seen_q <= 1'b1;
    end
  end

  always_comb begin
    if (!rst_ni) assert (!bx_o && !trig_o && !hit_o); // R1
  end

  AST_BX_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (bx_o == (gap_q == 3'd7))); // R2
  AST_BX_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bx_o |=> !bx_o); // R2
  AST_WORD_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_word != '0) && (hit_word != '0)); // R3
  AST_TRIG_IN_BX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> bx_o); // R4
  AST_ZERO_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_thresh_i == '0) |=> !trig_o); // R5
  AST_ZERO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_thresh_i == '0) |=> !hit_o); // R6
  AST_FULL_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_thresh_i == '1) |=> hit_o); // R6
endmodule

bind rand_trig_hit_gen rtg_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .trig_thresh_i(trig_thresh_i), .hit_thresh_i(hit_thresh_i),
  .bx_o(bx_o), .trig_o(trig_o), .hit_o(hit_o),
  .trig_word(trig_word), .hit_word(hit_word));

// File: tb/rand_trig_hit_gen_test.sv
module rand_trig_hit_gen_test;
  localparam logic [31:0] POLY = 32'h8020_0003;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] trig_th = 32'hFFFF_FFFF;
  logic [31:0] hit_th  = 32'hFFFF_FFFF;
  logic        bx, trig, hit;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  // item: {window, bx, trig, hit}
  logic [3:0] sb_q[$];
  logic [31:0] m_t = 32'h0000_0001, m_h = 32'hACE1_2468;
  int m_ph = 0;
  int trig_cnt = 0, hit_cnt = 0;

  always #5 clk = ~clk;

  rand_trig_hit_gen uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .trig_thresh_i(trig_th), .hit_thresh_i(hit_th),
    .bx_o(bx), .trig_o(trig), .hit_o(hit));

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s[0] ? ((s >> 1) ^ POLY) : (s >> 1);
  endfunction

  // driver: called at a falling edge, predicts the output after the next rise
  task automatic step(input logic [31:0] t, input logic [31:0] h, input bit win);
    logic eb, et, eh;
    trig_th = t;
    hit_th  = h;
    eb = (m_ph == 0);                 // R2
    et = eb && (m_t < t);             // R4 R8
    eh = (m_h < h);                   // R6 R8
    sb_q.push_back({win, eb, et, eh});
    m_t  = nxt(m_t);                  // R3
    m_h  = nxt(m_h);
    m_ph = (m_ph + 1) % 8;
    @(negedge clk);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      logic [3:0] e;
      e = sb_q.pop_front();
      checks++;
      if ({bx, trig, hit} !== e[2:0]) begin
        fails++;
        $display("FAIL R2/R3/R4/R6 scoreboard: got bx,trig,hit=%b%b%b expected %b",
                 bx, trig, hit, e[2:0]);
      end
      if (e[3]) begin
        trig_cnt += int'(trig);
        hit_cnt  += int'(hit);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: quiet during reset even with full thresholds
    check(!bx && !trig && !hit, "R1", {bx, trig, hit}, 0);
    rst_ni = 1'b1;

    // R5 R6: zero thresholds
    trig_cnt = 0; hit_cnt = 0;
    for (int i = 0; i < 400; i++) step(32'h0, 32'h0, 1'b1);
    @(posedge clk); #2;
    check(trig_cnt == 0, "R5 zero trigger threshold", trig_cnt, 0);
    check(hit_cnt == 0, "R6 zero hit threshold", hit_cnt, 0);
    @(negedge clk);
    // realign: one unmodelled edge passed, keep model in step
    m_t = nxt(m_t); m_h = nxt(m_h); m_ph = (m_ph + 1) % 8;

    // R5 R6: full thresholds
    trig_cnt = 0; hit_cnt = 0;
    for (int i = 0; i < 64; i++) step(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    @(posedge clk); #2;
    check(trig_cnt == 8, "R5 full trigger threshold", trig_cnt, 8);
    check(hit_cnt == 64, "R6 full hit threshold", hit_cnt, 64);
    @(negedge clk);
    m_t = nxt(m_t); m_h = nxt(m_h); m_ph = (m_ph + 1) % 8;

    // R8: random thresholds changing every 16 clocks
    for (int b = 0; b < 128; b++) begin
      logic [31:0] rt, rh;
      rt = $urandom;
      rh = $urandom;
      for (int i = 0; i < 16; i++) step(rt, rh, 1'b0);
    end

    // R7: rate window of 2^16 clocks
    trig_cnt = 0; hit_cnt = 0;
    for (int i = 0; i < 65536; i++) step(32'h8000_0000, 32'h4000_0000, 1'b1);
    @(posedge clk); #2;
    check(trig_cnt >= 3696 && trig_cnt <= 4496, "R7 trigger rate", trig_cnt, 4096);
    check(hit_cnt >= 15360 && hit_cnt <= 17408, "R7 hit rate", hit_cnt, 16384);
    check(sb_q.size() == 0, "R3 scoreboard drained", sb_q.size(), 0);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule